// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block sits beside the decode stage of a five-stage in-order pipeline whose conditional branches (branch-if-equal) are resolved in decode. It owns the equality comparator and the target adder, chooses where each comparator operand comes from, and holds the front of the pipeline while an operand is still being produced further down.

Its inputs are the decode slot's two source register numbers, its branch flag, immediate and PC+4, together with the register-file read data. It also takes the destination number, write flag and load flag of the instructions in EX and MEM, and the destination, write flag and write-back data of the instruction in WB.

It drives the PC and IF/ID write enables, a bubble request for ID/EX, two forwarding selects, the taken decision, the IF/ID flush and the branch target. It is purely combinational from its data inputs to its outputs. The clock and reset only time the embedded assertions.

Top module: `branch_hazard_unit`

## Requirements
- R1: `br_target_o` always equals `id_pc4_i` plus the sign-extended 16-bit `id_offset_i` shifted left by two bits.
- R2: When `id_branch_i` is 1 and no stall is requested, `br_taken_o` is 1 exactly when the two selected comparator operands are equal. `ifid_flush_o` equals `br_taken_o`.
- R3: A source register that matches the MEM destination of a register-writing non-load instruction is forwarded from `mem_result_i` with select code 2'b01, and no stall results.
- R4: A source register that matches the WB destination of a register-writing instruction is forwarded from `wb_data_i` with select code 2'b10, and no stall results. When MEM and WB both match, MEM (2'b01) wins. With no match the select is 2'b00 (register file).
- R5: A branch whose source register matches the EX destination of a register-writing instruction stalls. A producer whose write flag is 0 causes neither a stall nor a forward.
- R6: A branch whose source register matches the MEM destination of a register-writing load stalls.
- R7: A branch whose source register is loaded by the instruction in EX stalls. As that load advances to MEM it stalls again, so the branch is held for two cycles in total and then resolves using the WB forward.
- R8: During a stall `pc_write_o`=0, `ifid_write_o`=0 and `idex_bubble_o`=1. Otherwise the values are 1, 1 and 0.
- R9: Register 0 never causes a stall and is never forwarded (its select is always 2'b00).
- R10: A stalled branch is never taken and never flushes, even when its current operands compare equal.
- R11: When `id_branch_i` is 0 there is no stall, no taken decision and no flush, whatever the EX and MEM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to time the assertions |
| rst_n | input | 1 | Active-low reset, disables the assertions |
| id_branch_i | input | 1 | Decode slot holds a branch-if-equal |
| id_rs_i | input | 5 | First source register number |
| id_rt_i | input | 5 | Second source register number |
| id_pc4_i | input | 32 | PC+4 of the decode slot |
| id_offset_i | input | 16 | Branch word offset |
| rf_rs_data_i | input | 32 | Register-file data for the first source |
| rf_rt_data_i | input | 32 | Register-file data for the second source |
| ex_dst_i | input | 5 | EX destination register |
| ex_wr_i | input | 1 | EX instruction writes a register |
| ex_load_i | input | 1 | EX instruction is a load |
| mem_dst_i | input | 5 | MEM destination register |
| mem_wr_i | input | 1 | MEM instruction writes a register |
| mem_load_i | input | 1 | MEM instruction is a load |
| mem_result_i | input | 32 | ALU result held in the MEM stage |
| wb_dst_i | input | 5 | WB destination register |
| wb_wr_i | input | 1 | WB instruction writes a register |
| wb_data_i | input | 32 | Value being written back |
| pc_write_o | output | 1 | PC may update |
| ifid_write_o | output | 1 | IF/ID register may update |
| idex_bubble_o | output | 1 | Insert zero controls into ID/EX |
| fwd_rs_sel_o | output | 2 | First operand source: 00 file, 01 MEM, 10 WB |
| fwd_rt_sel_o | output | 2 | Second operand source: 00 file, 01 MEM, 10 WB |
| br_taken_o | output | 1 | Branch resolved taken |
| ifid_flush_o | output | 1 | Zero the controls of the fetched slot |
| br_target_o | output | 32 | Branch target address |

## Verification
The bench targets the distance-dependent stall rules. An ALU producer one instruction back must stall while a producer two back must forward; a unit that confused them would either read a stale value or waste a cycle. The load-in-EX case is walked cycle by cycle so that a unit stalling once instead of twice resolves with stale data and reports the wrong taken value. Register 0, write-disabled producers, the MEM-over-WB priority and a stalled branch with equal stale operands each get their own check. Any of these done wrong shows as a spurious stall, a wrong select, or a flush issued before the operands are valid.

// File: rtl/bhu_pkg.sv
package bhu_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'b00,
        SRC_MEM = 2'b01,
        SRC_WB  = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
        logic flush;
    } front_ctl_t;

endpackage

// File: rtl/bhu_stall_detect.sv
module bhu_stall_detect #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned N_SRC = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         branch_i,
    input  logic [N_SRC-1:0][REG_W-1:0]  src_i,
    input  logic [REG_W-1:0]             ex_dst_i,
    input  logic                         ex_wr_i,
    input  logic                         ex_load_i,
    input  logic [REG_W-1:0]             mem_dst_i,
    input  logic                         mem_wr_i,
    input  logic                         mem_load_i,
    output logic                         stall_o
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [N_SRC-1:0] need_wait_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic ex_hit_d;
        logic mem_ld_hit_d;
        always_comb begin
            ex_hit_d     = ex_wr_i && (ex_dst_i != ZERO_REG) && (ex_dst_i == src_i[g]);
            mem_ld_hit_d = mem_wr_i && mem_load_i && (mem_dst_i != ZERO_REG)
                           && (mem_dst_i == src_i[g]);
            need_wait_d[g] = ex_hit_d || mem_ld_hit_d;
        end
    end

    always_comb begin
        stall_o = branch_i && (|need_wait_d);
    end

    // R11: only a branch can be held by this unit
    a_r11_no_stall_without_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_i |-> !stall_o);

    // R7: a branch reading the register loaded by the EX instruction must wait
    a_r7_ex_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && ex_wr_i && ex_load_i && (ex_dst_i != ZERO_REG)
         && (ex_dst_i == src_i[0])) |-> stall_o);

endmodule

// File: rtl/bhu_fwd_mux.sv
module bhu_fwd_mux
    import bhu_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned XLEN  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_i,
    input  logic [XLEN-1:0]  rf_data_i,
    input  logic [REG_W-1:0] mem_dst_i,
    input  logic             mem_wr_i,
    input  logic             mem_load_i,
    input  logic [XLEN-1:0]  mem_result_i,
    input  logic [REG_W-1:0] wb_dst_i,
    input  logic             wb_wr_i,
    input  logic [XLEN-1:0]  wb_data_i,
    output opnd_src_e        sel_o,
    output logic [XLEN-1:0]  val_o
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_hit_d;
    logic wb_hit_d;

    always_comb begin
        mem_hit_d = mem_wr_i && !mem_load_i && (mem_dst_i != ZERO_REG)
                    && (mem_dst_i == src_i);
        wb_hit_d  = wb_wr_i && (wb_dst_i != ZERO_REG) && (wb_dst_i == src_i);
        if (mem_hit_d) begin
            sel_o = SRC_MEM;
        end else if (wb_hit_d) begin
            sel_o = SRC_WB;
        end else begin
            sel_o = SRC_RF;
        end
        case (sel_o)
            SRC_MEM: val_o = mem_result_i;
            SRC_WB:  val_o = wb_data_i;
            default: val_o = rf_data_i;
        endcase
    end

    // R9: register 0 always comes from the register file
    a_r9_zero_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == ZERO_REG) |-> (sel_o == SRC_RF));

    // R3: a load in MEM has no value yet and must never be selected
    a_r3_no_mem_load_forward: assert property (@(posedge clk) disable iff (!rst_n)
        mem_load_i |-> (sel_o != SRC_MEM));

endmodule

// File: rtl/bhu_resolve.sv
module bhu_resolve #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             branch_i,
    input  logic             stall_i,
    input  logic [XLEN-1:0]  opnd_a_i,
    input  logic [XLEN-1:0]  opnd_b_i,
    input  logic [XLEN-1:0]  pc4_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic             taken_o,
    output logic [XLEN-1:0]  target_o
);

    localparam int unsigned EXT_W = XLEN - OFS_W - 2;

    logic [XLEN-1:0] disp_d;
    logic            equal_d;

    always_comb begin
        disp_d   = {{EXT_W{offset_i[OFS_W-1]}}, offset_i, 2'b00};
        target_o = pc4_i + disp_d;
        equal_d  = (opnd_a_i == opnd_b_i);
        taken_o  = branch_i && !stall_i && equal_d;
    end

    // R10: a held branch is never resolved
    a_r10_stall_blocks_taken: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !taken_o);

    // R2: taken only for a branch
    a_r2_taken_is_branch: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> branch_i);

endmodule

// File: rtl/branch_hazard_unit.sv
module branch_hazard_unit
    import bhu_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_branch_i,
    input  logic [REG_W-1:0] id_rs_i,
    input  logic [REG_W-1:0] id_rt_i,
    input  logic [XLEN-1:0]  id_pc4_i,
    input  logic [OFS_W-1:0] id_offset_i,
    input  logic [XLEN-1:0]  rf_rs_data_i,
    input  logic [XLEN-1:0]  rf_rt_data_i,
    input  logic [REG_W-1:0] ex_dst_i,
    input  logic             ex_wr_i,
    input  logic             ex_load_i,
    input  logic [REG_W-1:0] mem_dst_i,
    input  logic             mem_wr_i,
    input  logic             mem_load_i,
    input  logic [XLEN-1:0]  mem_result_i,
    input  logic [REG_W-1:0] wb_dst_i,
    input  logic             wb_wr_i,
    input  logic [XLEN-1:0]  wb_data_i,
    output logic             pc_write_o,
    output logic             ifid_write_o,
    output logic             idex_bubble_o,
    output logic [1:0]       fwd_rs_sel_o,
    output logic [1:0]       fwd_rt_sel_o,
    output logic             br_taken_o,
    output logic             ifid_flush_o,
    output logic [XLEN-1:0]  br_target_o
);

    localparam int unsigned N_SRC = 2;

    logic [N_SRC-1:0][REG_W-1:0] src_d;
    logic [N_SRC-1:0][XLEN-1:0]  rf_d;
    logic [N_SRC-1:0][XLEN-1:0]  opnd_d;
    opnd_src_e                   sel_d [N_SRC];
    logic                        stall_d;
    logic                        taken_d;
    front_ctl_t                  ctl_d;

    always_comb begin
        src_d[0] = id_rs_i;
        src_d[1] = id_rt_i;
        rf_d[0]  = rf_rs_data_i;
        rf_d[1]  = rf_rt_data_i;
    end

    bhu_stall_detect #(
        .REG_W (REG_W),
        .N_SRC (N_SRC)
    ) i_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .branch_i   (id_branch_i),
        .src_i      (src_d),
        .ex_dst_i   (ex_dst_i),
        .ex_wr_i    (ex_wr_i),
        .ex_load_i  (ex_load_i),
        .mem_dst_i  (mem_dst_i),
        .mem_wr_i   (mem_wr_i),
        .mem_load_i (mem_load_i),
        .stall_o    (stall_d)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
        bhu_fwd_mux #(
            .REG_W (REG_W),
            .XLEN  (XLEN)
        ) i_fwd (
            .clk          (clk),
            .rst_n        (rst_n),
            .src_i        (src_d[g]),
            .rf_data_i    (rf_d[g]),
            .mem_dst_i    (mem_dst_i),
            .mem_wr_i     (mem_wr_i),
            .mem_load_i   (mem_load_i),
            .mem_result_i (mem_result_i),
            .wb_dst_i     (wb_dst_i),
            .wb_wr_i      (wb_wr_i),
            .wb_data_i    (wb_data_i),
            .sel_o        (sel_d[g]),
            .val_o        (opnd_d[g])
        );
    end

    bhu_resolve #(
        .XLEN  (XLEN),
        .OFS_W (OFS_W)
    ) i_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .branch_i (id_branch_i),
        .stall_i  (stall_d),
        .opnd_a_i (opnd_d[0]),
        .opnd_b_i (opnd_d[1]),
        .pc4_i    (id_pc4_i),
        .offset_i (id_offset_i),
        .taken_o  (taken_d),
        .target_o (br_target_o)
    );

    always_comb begin
        ctl_d.pc_we   = !stall_d;
        ctl_d.ifid_we = !stall_d;
        ctl_d.bubble  = stall_d;
        ctl_d.flush   = taken_d;
    end

    always_comb begin
        pc_write_o    = ctl_d.pc_we;
        ifid_write_o  = ctl_d.ifid_we;
        idex_bubble_o = ctl_d.bubble;
        ifid_flush_o  = ctl_d.flush;
        br_taken_o    = taken_d;
        fwd_rs_sel_o  = sel_d[0];
        fwd_rt_sel_o  = sel_d[1];
    end

    // R10: flush and bubble are never requested together
    a_r10_bubble_excludes_flush: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble_o |-> !ifid_flush_o);

    // R8: a frozen front end always goes with a bubble
    a_r8_freeze_with_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_write_o |-> (idex_bubble_o && !ifid_write_o));

endmodule

// File: tb/test_branch_hazard_unit.sv
module test_branch_hazard_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br = 1'b0;
    logic [4:0]  rs = '0, rt = '0;
    logic [31:0] pc4 = '0;
    logic [15:0] ofs = '0;
    logic [31:0] rfa = '0, rfb = '0;
    logic [4:0]  exd = '0;
    logic        exw = 1'b0, exl = 1'b0;
    logic [4:0]  memd = '0;
    logic        memw = 1'b0, meml = 1'b0;
    logic [31:0] memv = '0;
    logic [4:0]  wbd = '0;
    logic        wbw = 1'b0;
    logic [31:0] wbv = '0;
    logic        pcw, ifw, bub, tk, fl;
    logic [1:0]  sa, sb;
    logic [31:0] tgt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    branch_hazard_unit i_branch_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_branch_i(br), .id_rs_i(rs), .id_rt_i(rt),
        .id_pc4_i(pc4), .id_offset_i(ofs), .rf_rs_data_i(rfa), .rf_rt_data_i(rfb),
        .ex_dst_i(exd), .ex_wr_i(exw), .ex_load_i(exl),
        .mem_dst_i(memd), .mem_wr_i(memw), .mem_load_i(meml), .mem_result_i(memv),
        .wb_dst_i(wbd), .wb_wr_i(wbw), .wb_data_i(wbv),
        .pc_write_o(pcw), .ifid_write_o(ifw), .idex_bubble_o(bub),
        .fwd_rs_sel_o(sa), .fwd_rt_sel_o(sb), .br_taken_o(tk),
        .ifid_flush_o(fl), .br_target_o(tgt)
    );

    typedef struct packed {
        logic        br;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  exd;
        logic        exw;
        logic        exl;
        logic [4:0]  memd;
        logic        memw;
        logic        meml;
        logic [4:0]  wbd;
        logic        wbw;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] mv;
        logic [31:0] wv;
        logic        stall;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic        tk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R2: no hazard, equal -> taken
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd0, 32'd0, 1'b0, 2'd0, 2'd0, 1'b1, 8'd2},
        // R2: no hazard, unequal -> not taken
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd6, 32'd0, 32'd0, 1'b0, 2'd0, 2'd0, 1'b0, 8'd2},
        // R3: ALU in MEM feeds first operand
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd6, 32'd6, 32'd0, 1'b0, 2'd1, 2'd0, 1'b1, 8'd3},
        // R4: WB feeds second operand
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd2, 1'b1,
          32'd5, 32'd9, 32'd0, 32'd5, 1'b0, 2'd0, 2'd2, 1'b1, 8'd4},
        // R4: MEM beats WB for the same register
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 5'd1, 1'b1,
          32'd5, 32'd7, 32'd7, 32'd8, 1'b0, 2'd1, 2'd0, 1'b1, 8'd4},
        // R5 and R10: ALU in EX -> stall, equal stale operands not taken
        '{1'b1, 5'd1, 5'd2, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd0, 32'd0, 1'b1, 2'd0, 2'd0, 1'b0, 8'd5},
        // R5: write-disabled producer in EX is ignored
        '{1'b1, 5'd1, 5'd2, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd0, 32'd0, 1'b0, 2'd0, 2'd0, 1'b1, 8'd5},
        // R6: load in MEM -> stall
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b1, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd9, 32'd0, 1'b1, 2'd0, 2'd0, 1'b0, 8'd6},
        // R7: load in EX -> stall
        '{1'b1, 5'd1, 5'd2, 5'd2, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd0, 32'd0, 1'b1, 2'd0, 2'd0, 1'b0, 8'd7},
        // R9: register 0 everywhere -> no stall, no forward
        '{1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1,
          32'd0, 32'd0, 32'd3, 32'd4, 1'b0, 2'd0, 2'd0, 1'b1, 8'd9},
        // R11: not a branch, load in EX -> nothing
        '{1'b0, 5'd1, 5'd2, 5'd1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd5, 32'd0, 32'd0, 1'b0, 2'd0, 2'd0, 1'b0, 8'd11},
        // R3: ALU in MEM feeds second operand
        '{1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0,
          32'd5, 32'd1, 32'd5, 32'd0, 1'b0, 2'd0, 2'd1, 1'b1, 8'd3}
    };

    task automatic chk(input logic ok, input int req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        br = v.br; rs = v.rs; rt = v.rt;
        exd = v.exd; exw = v.exw; exl = v.exl;
        memd = v.memd; memw = v.memw; meml = v.meml; memv = v.mv;
        wbd = v.wbd; wbw = v.wbw; wbv = v.wv;
        rfa = v.a; rfb = v.b;
    endtask

    task automatic check_front(input logic exp_stall, input int req);
        // R8: stall outputs
        chk(pcw == !exp_stall, req, "pc_write", pcw, !exp_stall);
        chk(ifw == !exp_stall, req, "ifid_write", ifw, !exp_stall);
        chk(bub == exp_stall, req, "idex_bubble", bub, exp_stall);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R0 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // reset state: idle front end (R8, R11)
        #1;
        check_front(1'b0, 8);
        chk(fl == 1'b0, 11, "flush after reset", fl, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            check_front(VEC[i].stall, int'(VEC[i].req));
            chk(sa == VEC[i].sa, int'(VEC[i].req), "rs select", sa, VEC[i].sa);
            chk(sb == VEC[i].sb, int'(VEC[i].req), "rt select", sb, VEC[i].sb);
            chk(tk == VEC[i].tk, int'(VEC[i].req), "taken", tk, VEC[i].tk);
            chk(fl == VEC[i].tk, int'(VEC[i].req), "flush", fl, VEC[i].tk);
        end

        // R1: target with negative and positive offsets
        @(negedge clk);
        pc4 = 32'h0000_0100; ofs = 16'hFFFF;
        #1;
        chk(tgt == 32'h0000_00FC, 1, "target neg", tgt, 32'h0000_00FC);
        pc4 = 32'h0000_0100; ofs = 16'h0007;
        #1;
        chk(tgt == 32'h0000_011C, 1, "target pos", tgt, 32'h0000_011C);
        pc4 = 32'h8000_0000; ofs = 16'h8000;
        #1;
        chk(tgt == 32'h7FFE_0000, 1, "target min", tgt, 32'h7FFE_0000);

        // R7: load immediately ahead -> two held cycles, then WB forward
        begin : load_walk
            int held = 0;
            @(negedge clk);
            br = 1'b1; rs = 5'd3; rt = 5'd4; rfa = 32'd0; rfb = 32'd9;
            exd = 5'd3; exw = 1'b1; exl = 1'b1;
            memd = 5'd0; memw = 1'b0; meml = 1'b0;
            wbd = 5'd0; wbw = 1'b0;
            #1; if (bub) held++;
            @(negedge clk);  // load moves to MEM, bubble in EX
            exd = 5'd0; exw = 1'b0; exl = 1'b0;
            memd = 5'd3; memw = 1'b1; meml = 1'b1; memv = 32'd1;
            #1; if (bub) held++;
            chk(tk == 1'b0, 7, "taken while load in MEM", tk, 0);
            @(negedge clk);  // load reaches WB
            memd = 5'd0; memw = 1'b0; meml = 1'b0;
            wbd = 5'd3; wbw = 1'b1; wbv = 32'd9;
            #1; if (bub) held++;
            chk(held == 2, 7, "held cycles", held, 2);
            chk(sa == 2'd2, 7, "rs select after load", sa, 2);
            chk(tk == 1'b1, 7, "taken after load", tk, 1);
        end

        // R10: load in MEM with equal stale operands stays unresolved
        @(negedge clk);
        br = 1'b1; rs = 5'd5; rt = 5'd6; rfa = 32'd2; rfb = 32'd2;
        wbw = 1'b0; memd = 5'd6; memw = 1'b1; meml = 1'b1;
        #1;
        chk(fl == 1'b0, 10, "flush while held", fl, 0);
        chk(bub == 1'b1, 10, "bubble while held", bub, 1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule